// File: doc/BRIEF.md
# Pixel to Bus-Word Formatter

This block sits between a pixel source and the strobe timing engine of a parallel display bus. It takes pixels of 12, 16, 18 or 24 bits over a valid/ready stream. It slices them most-significant bit first into words as wide as the selected bus (8, 9, 12 or 16 lines) and hands those words on over a second valid/ready stream. The slicing depends on the ratio of pixel depth to bus width. A pixel may need one, two or three bus words. In the paired format, two pixels share three bus words, and the middle word takes half its bits from each pixel.

A frame update is armed by loading a pixel count, which is the area of the updated rectangle. A one-cycle start pulse then launches it. The transfer begins at once, or it holds until a tearing-effect event arrives, depending on a trigger-mode input. The block marks the final word of the frame and raises a one-cycle frame-done pulse when that word has been taken. Its busy flag then drops by itself. A start with a depth and bus-width pair that has no legal cycle format is refused, and a sticky error flag is raised.

Top module: `fmt_top`

## Requirements
- R1: Depth code `cfg_pix_fmt` selects 0=12, 1=16, 2=18, 3=24 bits per pixel, and bus code `cfg_bus_w` selects 0=8, 1=9, 2=12, 3=16 lines. Bits of `pix_data` above the selected depth are ignored.
- R2: The legal pairs are those whose depth is 1, 2 or 3 times the bus width, or 1.5 times it. These are 12/12, 16/16, 16/8, 18/9, 24/12, 24/8, 12/8, 18/12 and 24/16. A start with any other pair leaves `busy` low and sets `cfg_err`. An accepted start clears `cfg_err`.
- R3: When a pixel takes several words, they carry successive bus-width slices starting from the pixel's top bit. For 16 bits on 8 lines this is [15:8] then [7:0]; for 24 bits on 8 lines it is [23:16], [15:8], [7:0].
- R4: In the 1.5 ratio formats, each pair of pixels gives three words. Word one is the top bus-width bits of the first pixel. Word two is the low half-width of the first pixel above the top half-width of the second. Word three is the low bus-width bits of the second pixel.
- R5: In a 1.5 ratio format, an odd final pixel gives two words. The second of these has the pixel's low half-width in its upper half and zeros in its lower half.
- R6: Each word sits in the low bits of `word_data`, and all bits at and above the bus width are zero.
- R7: `word_last` marks the final word of the frame. `frame_done` is high for exactly the one cycle after that word's handshake, and `busy` is already low in that cycle.
- R8: In immediate trigger mode (`cfg_wait_te`=0), pixels are accepted from the cycle after the start edge.
- R9: In tearing-effect mode (`cfg_wait_te`=1), `busy` rises but no pixel is accepted and no word is offered until `te_evt` is sampled high. A `te_evt` sampled while idle has no effect.
- R10: A count write (`cnt_wr`) while `busy` is high has no effect, so a later frame started without a new write uses the earlier count.
- R11: A start while `busy` is high, or with a stored count of zero, has no effect.
- R12: While `word_valid` is high and `word_ready` is low, `word_valid`, `word_data` and `word_last` hold.
- R13: The depth and bus codes are captured at an accepted start. Changes to them during a frame do not alter that frame's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pix_fmt | input | 2 | Pixel depth code |
| cfg_bus_w | input | 2 | Bus width code |
| cfg_wait_te | input | 1 | 1 = hold start for tearing-effect event |
| te_evt | input | 1 | Tearing-effect event pulse |
| cnt_wr | input | 1 | Load pixel count |
| cnt_wdata | input | CNT_W | Pixel count value |
| start | input | 1 | Start pulse |
| busy | output | 1 | Frame in progress (self-clearing enable) |
| cfg_err | output | 1 | Last start refused for illegal format |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted when valid |
| pix_data | input | PIX_W | Pixel, right-aligned |
| word_valid | output | 1 | Word offered |
| word_ready | input | 1 | Word taken when valid |
| word_data | output | OUT_W | Bus word, right-aligned |
| word_last | output | 1 | Final word of the frame |

## Verification
Two pairs of events can share a cycle. One is the handshake of the frame's final word together with a count write or start pulse, which must still be ignored. The other is a mid-frame change of the format codes together with word output. The bench provokes both by holding `cnt_wr`, `start` and a changed depth code high for every cycle of a frame, the final-word cycle included, while both streams stall at random. It judges the outcome from the words, which must follow the captured format, from `busy` staying low after the done pulse, and from the next frame. That frame is started without a new count write, and its length must match the earlier count.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    CF_ONE   = 2'd0,
    CF_TWO   = 2'd1,
    CF_THREE = 2'd2,
    CF_PAIR  = 2'd3
  } cyc_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } xfer_st_e;

  function automatic logic [4:0] depth_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd16;
      2'd2:    return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [4:0] bus_lines(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

  // integer ratio 1..3, or 3 lines-worth per 2 pixels
  function automatic logic legal_combo(input logic [4:0] bpp, input logic [4:0] lines);
    int b;
    int l;
    b = int'(bpp);
    l = int'(lines);
    if (l == 0) return 1'b0;
    if ((b % l) == 0) return (b / l >= 1) && (b / l <= 3);
    return ((2 * b) % l == 0) && ((2 * b) / l == 3);
  endfunction

  function automatic cyc_fmt_e cycle_format(input logic [4:0] bpp, input logic [4:0] lines);
    int b;
    int l;
    b = int'(bpp);
    l = int'(lines);
    if (l == 0) return CF_ONE;
    if ((b % l) == 0) begin
      case (b / l)
        2:       return CF_TWO;
        3:       return CF_THREE;
        default: return CF_ONE;
      endcase
    end
    return CF_PAIR;
  endfunction

endpackage

// File: rtl/fmt_cfg_decode.sv
module fmt_cfg_decode
  import fmt_pkg::*;
(
  input  logic [1:0] pix_code,
  input  logic [1:0] bus_code,
  output logic [4:0] bpp,
  output logic [4:0] lines,
  output logic [1:0] words_per_grp,
  output logic       pair_mode
);

  cyc_fmt_e fmt;

  always_comb begin
    bpp           = depth_bits(pix_code);
    lines         = bus_lines(bus_code);
    fmt           = cycle_format(bpp, lines);
    pair_mode     = (fmt == CF_PAIR);
    words_per_grp = pair_mode ? 2'd3 : (2'(fmt) + 2'd1);
  end

endmodule

// File: rtl/fmt_frame_ctl.sv
module fmt_frame_ctl
  import fmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wait_te,
  input  logic             te_evt,
  input  logic             live_ok,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [1:0]       pix_code,
  input  logic [1:0]       bus_code,
  input  logic             pix_acc,
  input  logic             last_acc,
  output logic             busy,
  output logic             run,
  output logic             final_pix,
  output logic             cfg_err,
  output logic             frame_done,
  output logic [1:0]       lat_pix,
  output logic [1:0]       lat_bus,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  xfer_st_e         st_q;
  logic [CNT_W-1:0] rem_q;
  logic             start_ok;

  assign busy      = (st_q != ST_IDLE);
  assign run       = (st_q == ST_RUN);
  assign final_pix = (rem_q == ONE);
  assign start_ok  = start && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      cnt_q      <= '0;
      cfg_err    <= 1'b0;
      frame_done <= 1'b0;
      lat_pix    <= 2'd0;
      lat_bus    <= 2'd0;
    end else begin
      frame_done <= 1'b0;
      if (cnt_wr && (st_q == ST_IDLE)) cnt_q <= cnt_wdata;
      case (st_q)
        ST_IDLE: begin
          if (start_ok) begin
            if (!live_ok) begin
              cfg_err <= 1'b1;
            end else begin
              cfg_err <= 1'b0;
              lat_pix <= pix_code;
              lat_bus <= bus_code;
              rem_q   <= cnt_q;
              st_q    <= wait_te ? ST_WAIT : ST_RUN;
            end
          end
        end
        ST_WAIT: begin
          if (te_evt) st_q <= ST_RUN;
        end
        ST_RUN: begin
          if (pix_acc) rem_q <= rem_q - ONE;
          if (last_acc) begin
            st_q       <= ST_IDLE;
            frame_done <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fmt_pack.sv
module fmt_pack #(
  parameter int PIX_W = 24,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             final_pix,
  input  logic [4:0]       bpp,
  input  logic [4:0]       lines,
  input  logic [1:0]       words_per_grp,
  input  logic             pair_mode,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             pix_acc,
  input  logic             word_ready,
  output logic             word_valid,
  output logic [OUT_W-1:0] word_data,
  output logic             word_last,
  output logic             word_acc
);

  localparam int GW = 2 * PIX_W;
  localparam int BW = $clog2(GW + 1);

  // slice number idx (0 = most significant) of a gbits-wide group
  function automatic logic [OUT_W-1:0] take_word(input logic [GW-1:0] grp,
                                                 input logic [BW-1:0] gbits,
                                                 input logic [4:0]    nlines,
                                                 input logic [1:0]    idx);
    logic [BW-1:0] upto;
    logic [BW-1:0] shamt;
    upto  = (BW'(idx) + BW'(1)) * BW'(nlines);
    shamt = (gbits > upto) ? (gbits - upto) : '0;
    return OUT_W'(grp >> shamt) & ~({OUT_W{1'b1}} << nlines);
  endfunction

  logic             emit_q;
  logic             half_q;
  logic             fin_q;
  logic [1:0]       idx_q;
  logic [1:0]       nw_q;
  logic [GW-1:0]    grp_q;
  logic [PIX_W-1:0] hold_q;
  logic [PIX_W-1:0] pix_m;
  logic [BW-1:0]    gbits;
  logic             at_end;

  assign pix_m     = pix_data & ~({PIX_W{1'b1}} << bpp);
  assign gbits     = pair_mode ? (BW'(bpp) << 1) : BW'(bpp);
  assign pix_ready = run && !emit_q;
  assign pix_acc   = pix_valid && pix_ready;
  assign word_valid = emit_q;
  assign word_acc  = emit_q && word_ready;
  assign at_end    = (idx_q == (nw_q - 2'd1));
  assign word_last = emit_q && fin_q && at_end;
  assign word_data = emit_q ? take_word(grp_q, gbits, lines, idx_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emit_q <= 1'b0;
      half_q <= 1'b0;
      fin_q  <= 1'b0;
      idx_q  <= 2'd0;
      nw_q   <= 2'd1;
      grp_q  <= '0;
      hold_q <= '0;
    end else begin
      if (pix_acc) begin
        if (pair_mode && !half_q && !final_pix) begin
          hold_q <= pix_m;
          half_q <= 1'b1;
        end else begin
          emit_q <= 1'b1;
          idx_q  <= 2'd0;
          fin_q  <= final_pix;
          if (pair_mode) begin
            if (half_q) begin
              grp_q <= (GW'(hold_q) << bpp) | GW'(pix_m);
              nw_q  <= 2'd3;
            end else begin
              grp_q <= GW'(pix_m) << bpp;
              nw_q  <= 2'd2;
            end
          end else begin
            grp_q <= GW'(pix_m);
            nw_q  <= words_per_grp;
          end
        end
      end
      if (word_acc) begin
        if (at_end) begin
          emit_q <= 1'b0;
          half_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/fmt_top.sv
module fmt_top
  import fmt_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int OUT_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_pix_fmt,
  input  logic [1:0]       cfg_bus_w,
  input  logic             cfg_wait_te,
  input  logic             te_evt,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             start,
  output logic             busy,
  output logic             cfg_err,
  output logic             frame_done,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [OUT_W-1:0] word_data,
  output logic             word_last
);

  logic             live_ok;
  logic             run_w;
  logic             final_pix;
  logic             pix_acc;
  logic             word_acc;
  logic             last_acc;
  logic [1:0]       lat_pix;
  logic [1:0]       lat_bus;
  logic [CNT_W-1:0] cnt_q;
  logic [4:0]       lat_bpp;
  logic [4:0]       lat_lines;
  logic [1:0]       lat_wpg;
  logic             lat_pair;

  assign live_ok  = legal_combo(depth_bits(cfg_pix_fmt), bus_lines(cfg_bus_w));
  assign last_acc = word_acc && word_last;

  fmt_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_te(cfg_wait_te),
    .te_evt(te_evt), .live_ok(live_ok), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .pix_code(cfg_pix_fmt), .bus_code(cfg_bus_w), .pix_acc(pix_acc),
    .last_acc(last_acc), .busy(busy), .run(run_w), .final_pix(final_pix),
    .cfg_err(cfg_err), .frame_done(frame_done), .lat_pix(lat_pix),
    .lat_bus(lat_bus), .cnt_q(cnt_q)
  );

  fmt_cfg_decode u_dec (
    .pix_code(lat_pix), .bus_code(lat_bus), .bpp(lat_bpp), .lines(lat_lines),
    .words_per_grp(lat_wpg), .pair_mode(lat_pair)
  );

  fmt_pack #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .run(run_w), .final_pix(final_pix),
    .bpp(lat_bpp), .lines(lat_lines), .words_per_grp(lat_wpg),
    .pair_mode(lat_pair), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .pix_acc(pix_acc), .word_ready(word_ready),
    .word_valid(word_valid), .word_data(word_data), .word_last(word_last),
    .word_acc(word_acc)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int OUT_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             run,
  input logic             cfg_err,
  input logic             frame_done,
  input logic             pix_ready,
  input logic             word_valid,
  input logic             word_ready,
  input logic             word_last,
  input logic [OUT_W-1:0] word_data,
  input logic [4:0]       lat_lines,
  input logic [CNT_W-1:0] cnt_q
);

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy); // R2

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((word_data >> lat_lines) == '0)); // R6

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && word_last) |=> (frame_done && !busy)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> run); // R8

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run) |-> (!pix_ready && !word_valid)); // R9

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_q)); // R10

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && $stable(word_last))); // R12

endmodule

bind fmt_top fmt_checker #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .run(run_w), .cfg_err(cfg_err),
  .frame_done(frame_done), .pix_ready(pix_ready), .word_valid(word_valid),
  .word_ready(word_ready), .word_last(word_last), .word_data(word_data),
  .lat_lines(lat_lines), .cnt_q(cnt_q)
);

// File: tb/sim_fmt_top.sv
module sim_fmt_top;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_pix_fmt = 2'd0;
  logic [1:0]       cfg_bus_w = 2'd0;
  logic             cfg_wait_te = 1'b0;
  logic             te_evt = 1'b0;
  logic             cnt_wr = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic             start = 1'b0;
  logic             busy, cfg_err, frame_done, pix_ready, word_valid, word_last;
  logic             pix_valid = 1'b0;
  logic [23:0]      pix_data = '0;
  logic             word_ready = 1'b0;
  logic [15:0]      word_data;

  fmt_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pix_fmt(cfg_pix_fmt), .cfg_bus_w(cfg_bus_w),
    .cfg_wait_te(cfg_wait_te), .te_evt(te_evt), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .start(start), .busy(busy), .cfg_err(cfg_err),
    .frame_done(frame_done), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .word_last(word_last)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int          n_checks = 0;
  int          n_errs = 0;
  logic [23:0] pixq[$];
  logic [15:0] expq[$];
  int          pix_idx = 0;
  int          cur_bpp = 12;
  int          cur_lines = 8;
  bit          exp_done = 0;
  bit          got_done = 0;
  bit          rnd_ready = 0;
  bit          rnd_valid = 0;
  string       cur_req = "R3";

  function automatic int bpp_of(int c);
    int t[4] = '{12, 16, 18, 24};
    return t[c];
  endfunction

  function automatic int lines_of(int c);
    int t[4] = '{8, 9, 12, 16};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // reference: concatenate pixel bits MSB first, cut into bus-width words
  task automatic build(input int dt, input int bw, input int n);
    bit bits[$];
    cur_bpp   = bpp_of(dt);
    cur_lines = lines_of(bw);
    pixq.delete();
    expq.delete();
    pix_idx = 0;
    for (int i = 0; i < n; i++) begin
      logic [23:0] p;
      p = 24'($urandom) & ((24'h1 << cur_bpp) - 24'h1);
      pixq.push_back(p);
      for (int j = cur_bpp - 1; j >= 0; j--) bits.push_back(p[j]);
    end
    while (bits.size() > 0) begin
      logic [15:0] w;
      w = '0;
      for (int j = 0; j < cur_lines; j++)
        w = {w[14:0], (bits.size() > 0) ? bits.pop_front() : 1'b0};
      expq.push_back(w);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pix_valid = (pix_idx < pixq.size()) && (!rnd_valid || ($urandom % 4 != 0));
    // garbage above the pixel depth must be ignored (R1)
    pix_data = (pix_idx < pixq.size()) ?
               (pixq[pix_idx] | (24'hFFFFFF << cur_bpp)) : 24'h0;
    word_ready = !rnd_ready || ($urandom % 3 != 0);
    #1;
    if (exp_done) begin
      chk(frame_done === 1'b1 && busy === 1'b0, "R7", "done pulse after last word",
          {frame_done, busy}, 2'b10);
      exp_done = 0;
      got_done = 1;
    end else if (frame_done !== 1'b0) begin
      chk(0, "R7", "unexpected frame_done", frame_done, 0);
    end
    if (word_valid === 1'b1 && word_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R3", "extra word", word_data, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(word_data === e, cur_req, "word value", word_data, e);
        chk((word_data >> cur_lines) == 0, "R6", "upper bits zero", word_data >> cur_lines, 0);
        chk(word_last === (expq.size() == 0), "R7", "word_last flag", word_last, expq.size() == 0);
        if (expq.size() == 0) exp_done = 1;
      end
    end
    if (pix_valid && pix_ready === 1'b1) pix_idx++;
  endtask

  task automatic run_frame(input int dt, input int bw, input bit trig, input int n,
                           input bit rr, input bit rv, input bit poke,
                           input bit skipcnt, input string req);
    int cyc;
    cfg_pix_fmt = 2'(dt);
    cfg_bus_w   = 2'(bw);
    cfg_wait_te = trig;
    rnd_ready   = rr;
    rnd_valid   = rv;
    cur_req     = req;
    if (!skipcnt) begin
      cnt_wr = 1'b1;
      cnt_wdata = CNT_W'(n);
      step();
      cnt_wr = 1'b0;
    end
    build(dt, bw, n);
    got_done = 0;
    start = 1'b1;
    step();
    start = 1'b0;
    chk(busy === 1'b1, trig ? "R9" : "R8", "busy after start", busy, 1);
    chk(cfg_err === 1'b0, "R2", "error cleared by legal start", cfg_err, 0);
    if (trig) begin
      for (int i = 0; i < 4; i++) begin
        step();
        chk(pix_ready === 1'b0 && word_valid === 1'b0 && busy === 1'b1, "R9",
            "held for tearing event", {busy, pix_ready, word_valid}, 3'b100);
      end
      chk(pix_idx == 0, "R9", "no pixel taken before event", pix_idx, 0);
      te_evt = 1'b1;
      step();
      te_evt = 1'b0;
    end
    cyc = 0;
    while (!got_done && cyc < 3000) begin
      if (poke) begin
        cnt_wr = 1'b1;
        cnt_wdata = CNT_W'(2);
        start = 1'b1;
        cfg_pix_fmt = ~2'(dt);
      end
      step();
      cyc++;
    end
    cnt_wr = 1'b0;
    start = 1'b0;
    cfg_pix_fmt = 2'(dt);
    chk(got_done, req, "frame completed", got_done, 1);
    chk(pix_idx == pixq.size() && expq.size() == 0, req, "all pixels and words",
        expq.size(), 0);
    step();
    chk(busy === 1'b0, "R11", "idle after frame", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk(busy === 1'b0 && frame_done === 1'b0 && word_valid === 1'b0 &&
        pix_ready === 1'b0 && cfg_err === 1'b0, "R7", "reset state",
        {busy, frame_done, word_valid, pix_ready, cfg_err}, 0);
    rst_n = 1'b1;
    step();

    // tearing event while idle
    cfg_wait_te = 1'b1;
    te_evt = 1'b1;
    step();
    te_evt = 1'b0;
    step();
    chk(busy === 1'b0, "R9", "te while idle ignored", busy, 0);
    cfg_wait_te = 1'b0;

    // illegal pairs: 18/8 and 16/12
    cfg_pix_fmt = 2'd2; cfg_bus_w = 2'd0;
    cnt_wr = 1'b1; cnt_wdata = 16'd4; step(); cnt_wr = 1'b0;
    start = 1'b1; step(); start = 1'b0; step();
    chk(cfg_err === 1'b1 && busy === 1'b0, "R2", "18/8 refused", {cfg_err, busy}, 2'b10);
    cfg_pix_fmt = 2'd1; cfg_bus_w = 2'd2;
    start = 1'b1; step(); start = 1'b0; step();
    chk(cfg_err === 1'b1 && busy === 1'b0, "R2", "16/12 refused", {cfg_err, busy}, 2'b10);

    // whole-pixel formats
    run_frame(1, 0, 0, 6, 0, 0, 0, 0, "R3");
    run_frame(3, 0, 0, 5, 1, 1, 0, 0, "R3");
    run_frame(0, 2, 0, 7, 0, 1, 0, 0, "R1");
    run_frame(1, 3, 0, 4, 1, 0, 0, 0, "R1");
    run_frame(2, 1, 0, 5, 1, 1, 0, 0, "R3");
    run_frame(3, 2, 0, 4, 0, 0, 0, 0, "R3");

    // paired formats, even counts
    run_frame(0, 0, 0, 6, 0, 0, 0, 0, "R4");
    run_frame(2, 2, 0, 4, 1, 1, 0, 0, "R4");
    run_frame(3, 3, 0, 8, 1, 0, 0, 0, "R4");
    // paired formats, odd final pixel
    run_frame(0, 0, 0, 5, 1, 1, 0, 0, "R5");
    run_frame(3, 3, 0, 3, 0, 0, 0, 0, "R5");
    run_frame(2, 2, 0, 1, 0, 0, 0, 0, "R5");

    // tearing-effect trigger
    run_frame(1, 0, 1, 4, 1, 1, 0, 0, "R9");

    // zero count start ignored
    cfg_pix_fmt = 2'd1; cfg_bus_w = 2'd3;
    cnt_wr = 1'b1; cnt_wdata = '0; step(); cnt_wr = 1'b0;
    start = 1'b1; step(); start = 1'b0; step();
    chk(busy === 1'b0, "R11", "zero count start ignored", busy, 0);

    // count write, start and format change held through a whole frame
    run_frame(3, 2, 0, 6, 1, 1, 1, 0, "R13");
    // next frame with no new count write must still be 6 pixels
    run_frame(3, 2, 0, 6, 1, 0, 0, 1, "R10");

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule